// File: doc/BRIEF.md
# Delayed Branch Resolution Unit

This unit resolves the conditional, PC-relative branches of a 32-bit instruction set that has one branch delay slot. Each cycle it may accept one instruction word together with its address and the values of its two source registers. One cycle later it reports four things: whether the word was a legal branch, whether that branch was taken, and which address to fetch after the delay slot. It also reports whether the delay-slot instruction must be discarded.

Two kinds of branch exist. An ordinary branch always lets its delay-slot instruction run. A "likely" branch lets the delay-slot instruction run only when the branch is taken, and asks for it to be discarded when it is not. The unit keeps an internal flag that marks the instruction following an accepted branch as a delay-slot occupant. A branch found in that position is reported as illegal, as is any malformed branch encoding.

The unit holds no register file and fetches nothing. The pipeline around it supplies operands and acts on the resolved address and the discard request.

Top module: `brz_unit`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is zero and the delay-slot flag is clear.
- R2: A taken branch gives next address = pc + 4 + (sign-extended imm[15:0] shifted left by two), wrapping modulo 2^32.
- R3: A legal branch that is not taken gives next address = pc + 8.
- R4: Opcode bits [31:26] select the comparing branches: 0x04 and its likely form 0x14 are taken when rs equals rt. 0x05 and its likely form 0x15 are taken when rs differs from rt.
- R5: Opcode 0x06 and its likely form 0x16 are taken when rs <= 0. Opcode 0x07 and its likely form 0x17 are taken when rs > 0. Both are signed 32-bit tests.
- R6: Opcode 0x01 selects the operation through bits [20:16]: 0x00 is taken when rs < 0, 0x01 when rs >= 0, 0x02 when rs < 0 (likely form), and 0x03 when rs >= 0 (likely form).
- R7: The discard flag is 1 only for a legal likely branch that is not taken. It is 0 for every ordinary branch and for every taken branch.
- R8: Opcodes 0x06, 0x07, 0x16 and 0x17 with bits [20:16] nonzero set illegal and give is_branch = 0, taken = 0 and next address = pc + 4.
- R9: Opcode 0x01 with any value of bits [20:16] other than 0x00 to 0x03 sets illegal and gives is_branch = 0 and next address = pc + 4.
- R10: A branch in the next valid instruction after an accepted branch sets illegal and is not taken. The flag is cleared by that valid instruction and not by idle cycles.
- R11: A non-branch instruction gives is_branch = 0, taken = 0, illegal = 0 and next address = pc + 4.
- R12: Outputs are registered. out_valid follows in_valid one cycle later, and while out_valid is 0 every other output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_pc | input | 32 | Address of the instruction |
| in_instr | input | 32 | Instruction word |
| in_rs_val | input | 32 | Value of first source register |
| in_rt_val | input | 32 | Value of second source register |
| out_valid | output | 1 | Result present |
| out_is_branch | output | 1 | Instruction was a legal branch |
| out_taken | output | 1 | Branch taken |
| out_next_pc | output | 32 | Fetch address after the delay slot |
| out_annul | output | 1 | Discard the delay-slot instruction |
| out_illegal | output | 1 | Malformed branch or branch in delay slot |

## Verification
The hardest case to reach from the ports is the delay-slot rule. That rule depends on hidden state, and the state survives idle cycles. The bench follows a taken branch directly with a second branch, and the second must come back illegal. It then inserts idle cycles between a branch and its successor to show the flag waits for a valid instruction. Straight after that case, a legal branch shows that the flag was cleared.

// File: rtl/brz_pkg.sv
package brz_pkg;

    localparam int INSTR_W = 32;

    localparam logic [5:0] OP_REGIMM = 6'h01;
    localparam logic [5:0] OP_EQ     = 6'h04;
    localparam logic [5:0] OP_NE     = 6'h05;
    localparam logic [5:0] OP_LEZ    = 6'h06;
    localparam logic [5:0] OP_GTZ    = 6'h07;
    localparam logic [5:0] OP_EQ_L   = 6'h14;
    localparam logic [5:0] OP_NE_L   = 6'h15;
    localparam logic [5:0] OP_LEZ_L  = 6'h16;
    localparam logic [5:0] OP_GTZ_L  = 6'h17;

    localparam logic [4:0] SUB_LTZ   = 5'h00;
    localparam logic [4:0] SUB_GEZ   = 5'h01;
    localparam logic [4:0] SUB_LTZ_L = 5'h02;
    localparam logic [4:0] SUB_GEZ_L = 5'h03;

    typedef enum logic [2:0] {
        CND_NONE,
        CND_EQ,
        CND_NE,
        CND_LEZ,
        CND_GTZ,
        CND_LTZ,
        CND_GEZ
    } cond_e;

    typedef struct packed {
        logic  branch;
        logic  likely;
        logic  bad;
        cond_e cond;
    } dec_t;

    function automatic logic [5:0] f_opcode(input logic [INSTR_W-1:0] w);
        return w[31:26];
    endfunction

    function automatic logic [4:0] f_sub(input logic [INSTR_W-1:0] w);
        return w[20:16];
    endfunction

endpackage

// File: rtl/brz_decode.sv
module brz_decode
    import brz_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output dec_t               dec
);
    logic [5:0] op;
    logic [4:0] sub;

    assign op  = f_opcode(instr);
    assign sub = f_sub(instr);

    always_comb begin
        dec = '{branch: 1'b0, likely: 1'b0, bad: 1'b0, cond: CND_NONE};
        unique case (op)
            OP_EQ, OP_EQ_L: begin
                dec.branch = 1'b1;
                dec.likely = op[4];
                dec.cond   = CND_EQ;
            end
            OP_NE, OP_NE_L: begin
                dec.branch = 1'b1;
                dec.likely = op[4];
                dec.cond   = CND_NE;
            end
            OP_LEZ, OP_LEZ_L: begin
                dec.branch = 1'b1;
                dec.likely = op[4];
                dec.cond   = CND_LEZ;
                dec.bad    = (sub != 5'd0);
            end
            OP_GTZ, OP_GTZ_L: begin
                dec.branch = 1'b1;
                dec.likely = op[4];
                dec.cond   = CND_GTZ;
                dec.bad    = (sub != 5'd0);
            end
            OP_REGIMM: begin
                unique case (sub)
                    SUB_LTZ, SUB_LTZ_L: begin
                        dec.branch = 1'b1;
                        dec.likely = sub[1];
                        dec.cond   = CND_LTZ;
                    end
                    SUB_GEZ, SUB_GEZ_L: begin
                        dec.branch = 1'b1;
                        dec.likely = sub[1];
                        dec.cond   = CND_GEZ;
                    end
                    default: dec.bad = 1'b1;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/brz_cond.sv
module brz_cond
    import brz_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  cond_e             cond,
    input  logic [DATA_W-1:0] rs_val,
    input  logic [DATA_W-1:0] rt_val,
    output logic              hit
);
    logic neg;
    logic zero;
    logic same;

    assign neg  = rs_val[DATA_W-1];
    assign zero = (rs_val == '0);
    assign same = (rs_val == rt_val);

    always_comb begin
        unique case (cond)
            CND_EQ:  hit = same;
            CND_NE:  hit = !same;
            CND_LEZ: hit = neg || zero;
            CND_GTZ: hit = !neg && !zero;
            CND_LTZ: hit = neg;
            CND_GEZ: hit = !neg;
            default: hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/brz_target.sv
module brz_target #(
    parameter int ADDR_W = 32,
    parameter int IMM_W  = 16,
    parameter int WORD_B = 4
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [IMM_W-1:0]  imm,
    output logic [ADDR_W-1:0] seq_next,
    output logic [ADDR_W-1:0] seq_skip,
    output logic [ADDR_W-1:0] target
);
    localparam int SHIFT = $clog2(WORD_B);
    localparam int EXT_W = ADDR_W - IMM_W - SHIFT;

    logic [ADDR_W-1:0] offset;

    assign offset   = {{EXT_W{imm[IMM_W-1]}}, imm, {SHIFT{1'b0}}};
    assign seq_next = pc + ADDR_W'(WORD_B);
    assign seq_skip = pc + ADDR_W'(2 * WORD_B);
    assign target   = seq_next + offset;
endmodule

// File: rtl/brz_unit.sv
module brz_unit
    import brz_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_pc,
    input  logic [31:0]       in_instr,
    input  logic [DATA_W-1:0] in_rs_val,
    input  logic [DATA_W-1:0] in_rt_val,
    output logic              out_valid,
    output logic              out_is_branch,
    output logic              out_taken,
    output logic [ADDR_W-1:0] out_next_pc,
    output logic              out_annul,
    output logic              out_illegal
);
    typedef struct packed {
        logic              valid;
        logic              is_branch;
        logic              taken;
        logic [ADDR_W-1:0] next_pc;
        logic              annul;
        logic              illegal;
    } res_t;

    dec_t              dec;
    logic              hit;
    logic [ADDR_W-1:0] seq_next;
    logic [ADDR_W-1:0] seq_skip;
    logic [ADDR_W-1:0] target;
    logic              ds_q;
    logic              accept;
    res_t              res_d;
    res_t              res_q;

    brz_decode u_dec (
        .instr (in_instr),
        .dec   (dec)
    );

    brz_cond #(.DATA_W(DATA_W)) u_cond (
        .cond   (dec.cond),
        .rs_val (in_rs_val),
        .rt_val (in_rt_val),
        .hit    (hit)
    );

    brz_target #(.ADDR_W(ADDR_W)) u_tgt (
        .pc       (in_pc),
        .imm      (in_instr[15:0]),
        .seq_next (seq_next),
        .seq_skip (seq_skip),
        .target   (target)
    );

    assign accept = in_valid && dec.branch && !dec.bad && !ds_q;

    always_comb begin
        res_d = '0;
        if (in_valid) begin
            res_d.valid     = 1'b1;
            res_d.is_branch = accept;
            res_d.taken     = accept && hit;
            res_d.annul     = accept && dec.likely && !hit;
            res_d.illegal   = dec.bad || (dec.branch && ds_q);
            if (!accept)  res_d.next_pc = seq_next;
            else if (hit) res_d.next_pc = target;
            else          res_d.next_pc = seq_skip;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            ds_q  <= 1'b0;
        end else begin
            res_q <= res_d;
            if (in_valid) ds_q <= accept;
        end
    end

    assign out_valid     = res_q.valid;
    assign out_is_branch = res_q.is_branch;
    assign out_taken     = res_q.taken;
    assign out_next_pc   = res_q.next_pc;
    assign out_annul     = res_q.annul;
    assign out_illegal   = res_q.illegal;
endmodule

// File: rtl/brz_unit_chk.sv
module brz_unit_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [ADDR_W-1:0] in_pc,
    input logic              out_valid,
    input logic              out_is_branch,
    input logic              out_taken,
    input logic [ADDR_W-1:0] out_next_pc,
    input logic              out_annul,
    input logic              out_illegal
);
    logic slot_pending;

    always_ff @(posedge clk) begin
        if (rst) slot_pending <= 1'b0;
        else if (out_valid) slot_pending <= out_is_branch;
    end

    a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_is_branch && !out_taken && !out_annul
                        && !out_illegal && out_next_pc == '0));

    a_r7_annul_only_untaken: assert property (@(posedge clk) disable iff (rst)
        out_annul |-> (out_is_branch && !out_taken));

    a_r3_untaken_skips_slot: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_is_branch && !out_taken)
            |-> out_next_pc == $past(in_pc) + ADDR_W'(8));

    a_r11_plain_sequential: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_is_branch)
            |-> (!out_taken && out_next_pc == $past(in_pc) + ADDR_W'(4)));

    a_r8_illegal_not_branch: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> (!out_is_branch && !out_taken));

    a_r10_no_branch_in_slot: assert property (@(posedge clk) disable iff (rst)
        (out_valid && slot_pending) |-> !out_is_branch);
endmodule

bind brz_unit brz_unit_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_pc         (in_pc),
    .out_valid     (out_valid),
    .out_is_branch (out_is_branch),
    .out_taken     (out_taken),
    .out_next_pc   (out_next_pc),
    .out_annul     (out_annul),
    .out_illegal   (out_illegal)
);

// File: tb/brz_unit_bench.sv
`timescale 1ns/1ps
module brz_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_pc = '0;
    logic [31:0] in_instr = '0;
    logic [31:0] in_rs_val = '0;
    logic [31:0] in_rt_val = '0;
    logic        out_valid;
    logic        out_is_branch;
    logic        out_taken;
    logic [31:0] out_next_pc;
    logic        out_annul;
    logic        out_illegal;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    brz_unit u_brz_unit (
        .clk           (clk),
        .rst           (rst),
        .in_valid      (in_valid),
        .in_pc         (in_pc),
        .in_instr      (in_instr),
        .in_rs_val     (in_rs_val),
        .in_rt_val     (in_rt_val),
        .out_valid     (out_valid),
        .out_is_branch (out_is_branch),
        .out_taken     (out_taken),
        .out_next_pc   (out_next_pc),
        .out_annul     (out_annul),
        .out_illegal   (out_illegal)
    );

    function automatic logic [31:0] enc(input logic [5:0] op, input logic [4:0] rs,
                                        input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic [31:0] pc, input logic [31:0] ins,
                        input logic [31:0] rs, input logic [31:0] rt,
                        input logic eb, input logic et, input logic [31:0] en,
                        input logic ea, input logic ei, input string tag);
        @(negedge clk);
        in_valid = 1'b1; in_pc = pc; in_instr = ins; in_rs_val = rs; in_rt_val = rt;
        @(posedge clk); #1;
        chk(tag, "valid", {31'd0, out_valid}, 32'd1);
        chk(tag, "is_branch", {31'd0, out_is_branch}, {31'd0, eb});
        chk(tag, "taken", {31'd0, out_taken}, {31'd0, et});
        chk(tag, "next_pc", out_next_pc, en);
        chk(tag, "annul", {31'd0, out_annul}, {31'd0, ea});
        chk(tag, "illegal", {31'd0, out_illegal}, {31'd0, ei});
    endtask

    task automatic idle(input string tag);
        @(negedge clk);
        in_valid = 1'b0; in_pc = 32'hDEAD_BEEF; in_instr = 32'hFFFF_FFFF;
        @(posedge clk); #1;
        chk(tag, "valid", {31'd0, out_valid}, 32'd0);
        chk(tag, "quiet", {26'd0, out_is_branch, out_taken, out_annul, out_illegal, 2'b00}, 32'd0);
        chk(tag, "next_pc", out_next_pc, 32'd0);
    endtask

    // delay-slot filler: a plain instruction at pc
    task automatic slot(input logic [31:0] pc, input string tag);
        step(pc, 32'h0, 0, 0, 0, 0, pc + 4, 0, 0, tag);
    endtask

    task automatic t_reset();
        @(negedge clk); rst = 1'b1; in_valid = 1'b1; in_instr = enc(6'h04, 0, 0, 1);
        @(posedge clk); #1;
        chk("R1", "valid", {31'd0, out_valid}, 0);
        chk("R1", "flags", {28'd0, out_is_branch, out_taken, out_annul, out_illegal}, 0);
        chk("R1", "next_pc", out_next_pc, 0);
        @(negedge clk); rst = 1'b0; in_valid = 1'b0;
        @(posedge clk); #1;
        chk("R1", "after", {31'd0, out_valid}, 0);
        // flag must be clear: a branch right away is legal
        step(32'h100, enc(6'h04, 1, 2, 16'h0001), 5, 5, 1, 1, 32'h108, 0, 0, "R1 flag");
        slot(32'h104, "R1 slot");
    endtask

    task automatic t_equality();
        step(32'h1000, enc(6'h04, 1, 2, 16'h0003), 7, 7, 1, 1, 32'h1010, 0, 0, "R4 eq taken");
        slot(32'h1004, "R4 slot");
        step(32'h2000, enc(6'h04, 1, 2, 16'h0003), 7, 8, 1, 0, 32'h2008, 0, 0, "R3 eq untaken");
        slot(32'h2004, "R3 slot");
        step(32'h3000, enc(6'h05, 1, 2, 16'hFFFF), 1, 2, 1, 1, 32'h3000, 0, 0, "R2 ne back");
        slot(32'h3004, "R2 slot");
        step(32'h3100, enc(6'h05, 1, 2, 16'h0010), 9, 9, 1, 0, 32'h3108, 0, 0, "R4 ne untaken");
        slot(32'h3104, "R4 slot");
    endtask

    task automatic t_likely();
        step(32'h4000, enc(6'h14, 1, 2, 16'h0004), 1, 2, 1, 0, 32'h4008, 1, 0, "R7 eql untaken");
        slot(32'h4004, "R7 slot");
        step(32'h4100, enc(6'h14, 1, 2, 16'h0004), 3, 3, 1, 1, 32'h4114, 0, 0, "R7 eql taken");
        slot(32'h4104, "R7 slot");
        step(32'h4200, enc(6'h15, 1, 2, 16'h0002), 3, 4, 1, 1, 32'h420C, 0, 0, "R4 nel taken");
        slot(32'h4204, "R4 slot");
        step(32'h4300, enc(6'h15, 1, 2, 16'h0002), 4, 4, 1, 0, 32'h4308, 1, 0, "R7 nel untaken");
        slot(32'h4304, "R7 slot");
    endtask

    task automatic t_signed();
        step(32'h5000, enc(6'h06, 1, 0, 16'h0001), 0, 0, 1, 1, 32'h5008, 0, 0, "R5 lez zero");
        slot(32'h5004, "R5 slot");
        step(32'h5100, enc(6'h06, 1, 0, 16'h0001), 32'hFFFF_FFFB, 0, 1, 1, 32'h5108, 0, 0, "R5 lez neg");
        slot(32'h5104, "R5 slot");
        step(32'h5200, enc(6'h06, 1, 0, 16'h0001), 1, 0, 1, 0, 32'h5208, 0, 0, "R5 lez pos");
        slot(32'h5204, "R5 slot");
        step(32'h5300, enc(6'h07, 1, 0, 16'h0008), 32'h7FFF_FFFF, 0, 1, 1, 32'h5324, 0, 0, "R5 gtz max");
        slot(32'h5304, "R5 slot");
        step(32'h5400, enc(6'h07, 1, 0, 16'h0008), 32'h8000_0000, 0, 1, 0, 32'h5408, 0, 0, "R5 gtz min");
        slot(32'h5404, "R5 slot");
        step(32'h5500, enc(6'h07, 1, 0, 16'h0008), 0, 0, 1, 0, 32'h5508, 0, 0, "R5 gtz zero");
        slot(32'h5504, "R5 slot");
        step(32'h5600, enc(6'h16, 1, 0, 16'h0001), 1, 0, 1, 0, 32'h5608, 1, 0, "R7 lezl untaken");
        slot(32'h5604, "R7 slot");
        step(32'h5700, enc(6'h17, 1, 0, 16'h0001), 5, 0, 1, 1, 32'h5708, 0, 0, "R5 gtzl taken");
        slot(32'h5704, "R5 slot");
    endtask

    task automatic t_regimm();
        step(32'h6000, enc(6'h01, 1, 5'h00, 16'h0002), 32'hFFFF_FFFF, 0, 1, 1, 32'h600C, 0, 0, "R6 ltz taken");
        slot(32'h6004, "R6 slot");
        step(32'h6100, enc(6'h01, 1, 5'h00, 16'h0002), 0, 0, 1, 0, 32'h6108, 0, 0, "R6 ltz zero");
        slot(32'h6104, "R6 slot");
        step(32'h6200, enc(6'h01, 1, 5'h01, 16'h0002), 0, 0, 1, 1, 32'h620C, 0, 0, "R6 gez zero");
        slot(32'h6204, "R6 slot");
        step(32'h6300, enc(6'h01, 1, 5'h02, 16'h0002), 0, 0, 1, 0, 32'h6308, 1, 0, "R6 ltzl untaken");
        slot(32'h6304, "R6 slot");
        step(32'h6400, enc(6'h01, 1, 5'h03, 16'h0002), 32'h8000_0000, 0, 1, 0, 32'h6408, 1, 0, "R6 gezl untaken");
        slot(32'h6404, "R6 slot");
        step(32'h6500, enc(6'h01, 1, 5'h03, 16'h0002), 7, 0, 1, 1, 32'h650C, 0, 0, "R6 gezl taken");
        slot(32'h6504, "R6 slot");
    endtask

    task automatic t_malformed();
        step(32'h7000, enc(6'h07, 1, 5'h01, 16'h0002), 5, 0, 0, 0, 32'h7004, 0, 1, "R8 gtz rt");
        step(32'h7100, enc(6'h16, 1, 5'h1F, 16'h0002), 0, 0, 0, 0, 32'h7104, 0, 1, "R8 lezl rt");
        step(32'h7200, enc(6'h01, 1, 5'h10, 16'h0002), 0, 0, 0, 0, 32'h7204, 0, 1, "R9 sub 10");
        step(32'h7300, enc(6'h01, 1, 5'h04, 16'h0002), 0, 0, 0, 0, 32'h7304, 0, 1, "R9 sub 04");
        // malformed words do not open a delay slot
        step(32'h7400, enc(6'h04, 1, 2, 16'h0001), 1, 1, 1, 1, 32'h7408, 0, 0, "R8 no slot");
        slot(32'h7404, "R8 slot");
    endtask

    task automatic t_slot_rule();
        step(32'h8000, enc(6'h04, 1, 2, 16'h0001), 1, 1, 1, 1, 32'h8008, 0, 0, "R10 first");
        step(32'h8004, enc(6'h05, 1, 2, 16'h0001), 1, 2, 0, 0, 32'h8008, 0, 1, "R10 in slot");
        step(32'h8100, enc(6'h05, 1, 2, 16'h0001), 1, 2, 1, 1, 32'h8108, 0, 0, "R10 cleared");
        idle("R10 idle");
        idle("R10 idle");
        step(32'h8104, enc(6'h01, 1, 5'h01, 16'h0001), 0, 0, 0, 0, 32'h8108, 0, 1, "R10 after idle");
        step(32'h8200, enc(6'h14, 1, 2, 16'h0001), 1, 2, 1, 0, 32'h8208, 1, 0, "R10 likely ok");
        slot(32'h8204, "R10 slot");
    endtask

    task automatic t_wrap_plain();
        step(32'hFFFF_FFF0, enc(6'h04, 1, 2, 16'h7FFF), 0, 0, 1, 1, 32'h0001_FFF0, 0, 0, "R2 wrap");
        slot(32'hFFFF_FFF4, "R2 slot");
        step(32'h0000_0010, enc(6'h05, 1, 2, 16'h8000), 0, 1, 1, 1, 32'hFFFE_0014, 0, 0, "R2 min imm");
        slot(32'h0000_0014, "R2 slot");
        step(32'h9000, enc(6'h09, 1, 2, 16'h1234), 1, 2, 0, 0, 32'h9004, 0, 0, "R11 addiu");
        step(32'h9004, enc(6'h23, 1, 0, 16'hFFFF), 0, 0, 0, 0, 32'h9008, 0, 0, "R11 load rt0");
        idle("R12 idle");
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_equality();
        t_likely();
        t_signed();
        t_regimm();
        t_malformed();
        t_slot_rule();
        t_wrap_plain();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule